// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block supervises software through a single write port carrying an enable bit and a small key. Once armed, it counts ticks of a slow tick-enable strobe. If software lets a first timeout expire without a valid restart or stop, the block raises a non-maskable interrupt request. A crash handler then has a short grace period to act. If that grace period also expires, the block emits a one-cycle chip reset request and returns to the stopped state.

A restart or stop is accepted only when the written key is the bitwise inverse of the key the block currently holds. Software that follows the protocol therefore alternates between a key and its complement. A runaway write loop that repeats one value cannot keep the watchdog alive. A write with any other key does not restart or stop the timer. It only replaces the held key.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is stopped: `nmi_req` and `chip_rst_req` are 0, and tick strobes alone never raise either output.
- R2: While stopped, a write with `wr_arm` = 0 has no effect. The outputs stay 0 under any number of ticks.
- R3: While stopped, a write with `wr_arm` = 1 starts the block and stores `wr_key` as the held key. Ticks in the cycle of that write are not counted.
- R4: While running, a write with `wr_arm` = 1 and `wr_key` equal to the bitwise NOT of the held key restarts the first timeout. The written key becomes the held key.
- R5: While running, a write with `wr_arm` = 0 and `wr_key` equal to the bitwise NOT of the held key stops the block. `nmi_req` drops on the next cycle.
- R6: While running, a write whose `wr_key` is not the bitwise NOT of the held key only replaces the held key, whatever `wr_arm` is. The timeout keeps counting from where it was.
- R7: `nmi_req` rises in the cycle after the FIRST_TICKS-th tick strobe counted since the last start or restart. It stays high until a valid restart or stop, or until the reset pulse.
- R8: While `nmi_req` is high, the GRACE_TICKS-th further tick strobe produces a one-cycle pulse on `chip_rst_req`. In that same cycle `nmi_req` falls and the block is stopped.
- R9: A valid restart or stop in the same cycle as a tick that would expire a timeout takes priority. No NMI and no reset results from that tick.
- R10: Cycles with `tick_en` = 0 do not advance either timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timebase strobe, one count per high cycle |
| wr_en | input | 1 | Control write strobe |
| wr_arm | input | 1 | Enable bit of the control write |
| wr_key | input | KEY_W | Key field of the control write |
| nmi_req | output | 1 | First-stage expiry request, held |
| chip_rst_req | output | 1 | Second-stage expiry, one-cycle pulse |

## Verification
The hardest situation to reach from the ports is a valid inverse-key write that lands on exactly the tick that would end a timeout. It needs both the tick count and the held key to be known at that instant. Directed sequences count ticks precisely up to the expiring one and then present the complement of the key they last wrote, once during the first stage and once during the grace stage. Random stimulus favours the complement of the key predicted by the bench model. As a result, restarts, stops and key replacements are spread across every tick position, including those near expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      WDG_IDLE  = 2'd0,
      WDG_ARMED = 2'd1,
      WDG_GRACE = 2'd2
   } wdg_state_e;
endpackage

// File: rtl/wdg_key_judge.sv
module wdg_key_judge #(
   parameter int KEY_W = 3
) (
   input  logic             active,
   input  logic [KEY_W-1:0] key_q,
   input  logic             wr_en,
   input  logic             wr_arm,
   input  logic [KEY_W-1:0] wr_key,
   output logic             do_start,
   output logic             do_kick,
   output logic             do_stop,
   output logic             do_rekey
);
   logic inv_ok;

   always_comb begin
      inv_ok   = (wr_key == ~key_q);
      do_start = wr_en & ~active & wr_arm;
      do_kick  = wr_en & active & inv_ok & wr_arm;
      do_stop  = wr_en & active & inv_ok & ~wr_arm;
      do_rekey = wr_en & active & ~inv_ok;
   end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          at_one
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign at_one = (cnt_q == CW'(1));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdg_pkg::*;
#(
   parameter int KEY_W       = 3,
   parameter int FIRST_TICKS = 1920,
   parameter int GRACE_TICKS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic             wr_arm,
   input  logic [KEY_W-1:0] wr_key,
   output logic             nmi_req,
   output logic             chip_rst_req
);
   localparam int MAX_TICKS = (FIRST_TICKS > GRACE_TICKS) ? FIRST_TICKS : GRACE_TICKS;
   localparam int CW        = $clog2(MAX_TICKS + 1);

   if (KEY_W < 1) begin : g_bad_key
      $error("keyed_watchdog: KEY_W must be at least 1");
   end
   if (FIRST_TICKS < 1 || GRACE_TICKS < 1) begin : g_bad_ticks
      $error("keyed_watchdog: timeouts must be at least one tick");
   end

   wdg_state_e       state_q, state_d;
   logic [KEY_W-1:0] key_q;
   logic             rst_pulse_q;
   logic             active;
   logic             do_start, do_kick, do_stop, do_rekey;
   logic             at_one, expire, cnt_load, cnt_dec;
   logic [CW-1:0]    cnt_val;

   assign active = (state_q != WDG_IDLE);

   wdg_key_judge #(.KEY_W(KEY_W)) u_judge (
      .active   (active),
      .key_q    (key_q),
      .wr_en    (wr_en),
      .wr_arm   (wr_arm),
      .wr_key   (wr_key),
      .do_start (do_start),
      .do_kick  (do_kick),
      .do_stop  (do_stop),
      .do_rekey (do_rekey)
   );

   always_comb begin
      expire   = tick_en & active & at_one & ~(do_kick | do_stop);
      cnt_load = do_start | do_kick | (expire & (state_q == WDG_ARMED));
      cnt_val  = (do_start | do_kick) ? CW'(FIRST_TICKS) : CW'(GRACE_TICKS);
      cnt_dec  = tick_en & active & ~cnt_load;
   end

   wdg_countdown #(.CW(CW)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .at_one   (at_one)
   );

   always_comb begin
      state_d = state_q;
      if (do_start | do_kick)
         state_d = WDG_ARMED;
      else if (do_stop)
         state_d = WDG_IDLE;
      else if (expire)
         state_d = (state_q == WDG_ARMED) ? WDG_GRACE : WDG_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= WDG_IDLE;
         key_q       <= '0;
         rst_pulse_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         rst_pulse_q <= expire & (state_q == WDG_GRACE);
         if (do_start | do_kick | do_stop | do_rekey)
            key_q <= wr_key;
      end
   end

   assign nmi_req      = (state_q == WDG_GRACE);
   assign chip_rst_req = rst_pulse_q;
endmodule

module keyed_watchdog_chk #(
   parameter int KEY_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             wr_en,
   input logic             wr_arm,
   input logic [KEY_W-1:0] wr_key,
   input logic [KEY_W-1:0] key_q,
   input logic             active,
   input logic             nmi_req,
   input logic             chip_rst_req
);
   a_r8_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |=> !chip_rst_req);

   a_r8_rst_follows_nmi: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_rst_req) |-> $past(nmi_req));

   a_r8_rst_clears_nmi: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |-> (!nmi_req && !active));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !nmi_req);

   a_r5_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && active && !wr_arm && wr_key == ~key_q) |=> (!nmi_req && !chip_rst_req && !active));

   a_r4_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && active && wr_arm && wr_key == ~key_q) |=> (!nmi_req && !chip_rst_req && active));

   a_r6_key_replaced: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && active && wr_key != ~key_q) |=> (key_q == $past(wr_key)));

   a_r2_idle_disarm_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && wr_en && !wr_arm) |=> !active);

   a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_en) |=> ($stable(nmi_req) && !chip_rst_req));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.KEY_W(KEY_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_en      (tick_en),
   .wr_en        (wr_en),
   .wr_arm       (wr_arm),
   .wr_key       (wr_key),
   .key_q        (key_q),
   .active       (active),
   .nmi_req      (nmi_req),
   .chip_rst_req (chip_rst_req)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
   localparam int KW = 3;
   localparam int FT = 12;
   localparam int GT = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_arm = 1'b0;
   logic [KW-1:0] wr_key = '0;
   logic          nmi_req;
   logic          chip_rst_req;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_cnt = 0;

   // reference model state: 0 stopped, 1 first stage, 2 grace stage
   int          m_state = 0;
   logic [KW-1:0] m_key = '0;
   int          m_cnt = 0;
   logic        m_rst = 1'b0;

   keyed_watchdog #(.KEY_W(KW), .FIRST_TICKS(FT), .GRACE_TICKS(GT)) u_keyed_watchdog (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .wr_en        (wr_en),
      .wr_arm       (wr_arm),
      .wr_key       (wr_key),
      .nmi_req      (nmi_req),
      .chip_rst_req (chip_rst_req)
   );

   always #10 clk = ~clk;

   function automatic logic inv_hit(logic [KW-1:0] k, logic [KW-1:0] held);
      return k == ~held;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state <= 0; m_key <= '0; m_cnt <= 0; m_rst <= 1'b0;
      end else begin
         m_rst <= 1'b0;
         if (m_state == 0) begin
            if (wr_en && wr_arm) begin
               m_state <= 1; m_key <= wr_key; m_cnt <= FT;
            end
         end else if (wr_en && inv_hit(wr_key, m_key)) begin
            m_key <= wr_key;
            if (wr_arm) begin m_state <= 1; m_cnt <= FT; end
            else m_state <= 0;
         end else begin
            if (wr_en) m_key <= wr_key;
            if (tick_en) begin
               if (m_cnt == 1) begin
                  if (m_state == 1) begin m_state <= 2; m_cnt <= GT; end
                  else begin m_state <= 0; m_rst <= 1'b1; end
               end else m_cnt <= m_cnt - 1;
            end
         end
      end
   end

   task automatic check(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 nmi_req against model", nmi_req, m_state == 2);
         check("R8 chip_rst_req against model", chip_rst_req, m_rst);
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         finish_run();
      end
   end

   task automatic cyc(input logic w, input logic a, input logic [KW-1:0] k, input logic t);
      wr_en = w; wr_arm = a; wr_key = k; tick_en = t;
      @(negedge clk);
      wr_en = 1'b0; tick_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b1);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state and idle ticks
      check("R1 nmi after reset", nmi_req, 1'b0);
      check("R1 rst after reset", chip_rst_req, 1'b0);
      ticks(FT + GT + 4);
      check("R1 nmi stays low while stopped", nmi_req, 1'b0);
      // R2 disarm write while stopped
      cyc(1'b1, 1'b0, 3'd5, 1'b1);
      ticks(FT + GT + 4);
      check("R2 disarm write while stopped has no effect", nmi_req, 1'b0);
      // R3 start, R7 first timeout
      cyc(1'b1, 1'b1, 3'd3, 1'b1);
      ticks(FT - 1);
      check("R3 no nmi one tick before timeout", nmi_req, 1'b0);
      ticks(1);
      check("R7 nmi after first timeout", nmi_req, 1'b1);
      // R8 grace expiry
      ticks(GT - 1);
      check("R8 nmi held in grace", nmi_req, 1'b1);
      check("R8 no reset before grace end", chip_rst_req, 1'b0);
      ticks(1);
      check("R8 reset pulse at grace end", chip_rst_req, 1'b1);
      check("R8 nmi cleared with reset", nmi_req, 1'b0);
      ticks(1);
      check("R8 reset pulse lasts one cycle", chip_rst_req, 1'b0);
      // R4 restart with inverse key
      cyc(1'b1, 1'b1, 3'd2, 1'b0);
      ticks(FT - 2);
      cyc(1'b1, 1'b1, 3'd5, 1'b1);
      ticks(FT - 1);
      check("R4 restart reloads first timeout", nmi_req, 1'b0);
      ticks(1);
      check("R4 nmi after reloaded timeout", nmi_req, 1'b1);
      cyc(1'b1, 1'b1, 3'd2, 1'b0);
      check("R7 restart clears nmi", nmi_req, 1'b0);
      // R5 stop with inverse key
      cyc(1'b1, 1'b0, 3'd5, 1'b1);
      for (int i = 0; i < FT + GT + 4; i++) begin
         ticks(1);
         check("R5 stopped block stays quiet", nmi_req | chip_rst_req, 1'b0);
      end
      // R6 non-inverse writes only replace the key
      cyc(1'b1, 1'b1, 3'd1, 1'b0);
      cyc(1'b1, 1'b1, 3'd1, 1'b1);
      cyc(1'b1, 1'b0, 3'd4, 1'b1);
      ticks(FT - 3);
      check("R6 mismatched writes do not restart", nmi_req, 1'b0);
      ticks(1);
      check("R6 timeout counted through mismatched writes", nmi_req, 1'b1);
      cyc(1'b1, 1'b0, 3'd3, 1'b1);
      check("R6 replaced key accepted for stop", nmi_req, 1'b0);
      // R9 restart on the expiring tick, then stop on the grace-expiring tick
      cyc(1'b1, 1'b1, 3'd0, 1'b0);
      ticks(FT - 1);
      cyc(1'b1, 1'b1, 3'd7, 1'b1);
      check("R9 restart beats first expiry", nmi_req, 1'b0);
      ticks(FT - 1);
      check("R9 full timeout after collision restart", nmi_req, 1'b0);
      ticks(1);
      check("R9 nmi after timeout", nmi_req, 1'b1);
      ticks(GT - 1);
      cyc(1'b1, 1'b0, 3'd0, 1'b1);
      check("R9 stop beats grace expiry reset", chip_rst_req, 1'b0);
      check("R9 stop beats grace expiry nmi", nmi_req, 1'b0);
      // R10 idle cycles do not advance
      cyc(1'b1, 1'b1, 3'd6, 1'b0);
      ticks(FT - 1);
      repeat (20) cyc(1'b0, 1'b0, '0, 1'b0);
      check("R10 no advance without tick", nmi_req, 1'b0);
      ticks(1);
      check("R10 expiry on the final tick", nmi_req, 1'b1);
      cyc(1'b1, 1'b0, 3'd1, 1'b0);
      // random phase, compared every cycle against the model
      for (int i = 0; i < 4000; i++) begin
         logic w, a, t;
         logic [KW-1:0] k;
         w = ($urandom_range(0, 99) < 12);
         a = $urandom_range(0, 3) != 0;
         k = ($urandom_range(0, 1) == 1) ? ~m_key : KW'($urandom_range(0, 7));
         t = $urandom_range(0, 2) != 0;
         cyc(w, a, k, t);
      end
      finish_run();
   end
endmodule